// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This block turns one decoded load-coprocessor or store-coprocessor instruction into a stream of word addresses for the memory side. It also produces the single base-register writeback that the addressing form calls for. The issue stage presents the P, U and W bits, the 8-bit immediate, the base register number and its value with a one-cycle `start` pulse. The sequencer then presents one word address per cycle on `xfer_addr` while `xfer_valid` is high. An address is consumed on any cycle where `mem_ready` is high. The coprocessor ends the burst by raising `cp_last` alongside the final accepted word.

Three forms are supported. The pre-indexed form moves the first address by the scaled immediate and may write it back. The post-indexed form starts at the base and writes the moved base back at the end. The unindexed form (P=0, U=1, W=0) is one coprocessor burst starting at the base with no writeback, and its immediate byte goes to the coprocessor as an option value. The whole instruction is always treated as one coprocessor access, never as a core load/store plus a separate coprocessor access. The remaining P=0, U=0, W=0 combination is rejected.

Top module: `cpxfer_seq`

## Requirements
- R1: With P=0, U=1, W=0 (unindexed), the first address equals the base value and the burst runs until the coprocessor ends it.
- R2: An unindexed instruction never asserts `wb_en`.
- R3: During an unindexed burst `cp_opt` equals the immediate byte unchanged, and the addresses do not depend on it. In every other form `cp_opt` is zero.
- R4: The transfer accepted with `cp_last` high is the last one. `xfer_valid` is low in the next cycle, so no word after the requested ones is written, and `done` is high for exactly that one cycle.
- R5: With P=1 the first address is base + imm*4 when U=1 and base - imm*4 when U=0. If W=1 that address is written back, and if W=0 no writeback occurs.
- R6: With P=0, W=1 (post-indexed) the first address is the base, and base ± imm*4 (sign chosen by U) is written back.
- R7: P=0, U=0, W=0 raises `illegal` for one cycle, one cycle after `start`, and causes no transfer, no `busy` and no writeback.
- R8: Each accepted transfer advances the address by 4. While `mem_ready` is low the address holds and nothing advances.
- R9: Writeback happens at most once per instruction, only in the `done` cycle, and `wb_idx` equals the base field captured at `start`.
- R10: After reset `busy`, `xfer_valid`, `done`, `wb_en` and `illegal` are all low.
- R11: A `start` pulse that arrives while `busy` is high is ignored and does not disturb the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle issue pulse for a new instruction |
| p_bit | input | 1 | Pre-index select |
| u_bit | input | 1 | Up/down select |
| w_bit | input | 1 | Writeback select |
| imm | input | IMM_W | Immediate field: word offset or coprocessor options |
| base_idx | input | IDX_W | Base register number |
| base_val | input | AW | Base register value |
| mem_ready | input | 1 | Memory accepts the presented address this cycle |
| cp_last | input | 1 | Coprocessor marks the current accepted transfer as its last |
| busy | output | 1 | Instruction in progress |
| xfer_valid | output | 1 | `xfer_addr` holds a transfer address |
| xfer_addr | output | AW | Current word address |
| cp_opt | output | IMM_W | Option byte for the coprocessor |
| done | output | 1 | Instruction completes this cycle |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | IDX_W | Register written back |
| wb_val | output | AW | Value written back |
| illegal | output | 1 | Undefined addressing form rejected |

## Verification
The hardest case to reach from the ports is a burst where the coprocessor's end mark lands on a cycle after memory stalls. Address holding and the end-of-burst cut must both be seen at the same edge. The directed tasks drive `mem_ready` with an alternating stall pattern. They tie `cp_last` to the cycle where the final word is actually accepted, so the last word is sometimes preceded by a stall. A new `start` is also injected in the middle of a burst to show that it leaves the address stream untouched.

// File: rtl/cpxfer_pkg.sv
package cpxfer_pkg;
   typedef enum logic [1:0] {XM_PRE, XM_POST, XM_UNIDX, XM_BAD} xfer_mode_e;
   typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_FIN} seq_state_e;
endpackage

// File: rtl/cpxfer_decode.sv
module cpxfer_decode
   import cpxfer_pkg::*;
#(
   parameter int AW         = 32,
   parameter int IMM_W      = 8,
   parameter int WORD_BYTES = 4
) (
   input  logic             p_bit,
   input  logic             u_bit,
   input  logic             w_bit,
   input  logic [IMM_W-1:0] imm,
   input  logic [AW-1:0]    base_val,
   output xfer_mode_e       mode,
   output logic [AW-1:0]    first_addr,
   output logic [AW-1:0]    moved_base,
   output logic             wb_req
);
   localparam int SHIFT = $clog2(WORD_BYTES);

   logic [AW-1:0] imm_ext;
   logic [AW-1:0] offset;

   assign imm_ext = {{(AW-IMM_W){1'b0}}, imm};

   generate
      if (SHIFT == 0) begin : g_noscale
         assign offset = imm_ext;
      end else begin : g_scale
         assign offset = {imm_ext[AW-SHIFT-1:0], {SHIFT{1'b0}}};
      end
   endgenerate

   assign moved_base = u_bit ? (base_val + offset) : (base_val - offset);

   always_comb begin
      if (p_bit)      mode = XM_PRE;
      else if (w_bit) mode = XM_POST;
      else if (u_bit) mode = XM_UNIDX;
      else            mode = XM_BAD;
   end

   // unindexed form takes the raw base; the option byte never reaches an adder output used here
   assign first_addr = (mode == XM_PRE) ? moved_base : base_val;
   assign wb_req     = w_bit && (mode == XM_PRE || mode == XM_POST);
endmodule

// File: rtl/cpxfer_addr_gen.sv
module cpxfer_addr_gen #(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (step) addr <= addr + STRIDE;
   end
endmodule

// File: rtl/cpxfer_seq.sv
module cpxfer_seq
   import cpxfer_pkg::*;
#(
   parameter int AW         = 32,
   parameter int IMM_W      = 8,
   parameter int IDX_W      = 4,
   parameter int WORD_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             p_bit,
   input  logic             u_bit,
   input  logic             w_bit,
   input  logic [IMM_W-1:0] imm,
   input  logic [IDX_W-1:0] base_idx,
   input  logic [AW-1:0]    base_val,
   input  logic             mem_ready,
   input  logic             cp_last,
   output logic             busy,
   output logic             xfer_valid,
   output logic [AW-1:0]    xfer_addr,
   output logic [IMM_W-1:0] cp_opt,
   output logic             done,
   output logic             wb_en,
   output logic [IDX_W-1:0] wb_idx,
   output logic [AW-1:0]    wb_val,
   output logic             illegal
);
   localparam int SHIFT = $clog2(WORD_BYTES);

   generate
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || WORD_BYTES < 1) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (AW < IMM_W + SHIFT + 1) begin : g_bad_aw
         $error("AW too narrow for the scaled immediate");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   xfer_mode_e       dec_mode;
   logic [AW-1:0]    dec_first;
   logic [AW-1:0]    dec_moved;
   logic             dec_wb;

   seq_state_e       state;
   xfer_mode_e       mode_q;
   logic             wb_req_q;
   logic [AW-1:0]    wb_val_q;
   logic [IDX_W-1:0] wb_idx_q;
   logic [IMM_W-1:0] opt_q;
   logic             illegal_q;
   logic             accept;
   logic             launch;

   cpxfer_decode #(.AW(AW), .IMM_W(IMM_W), .WORD_BYTES(WORD_BYTES)) u_dec (
      .p_bit     (p_bit),
      .u_bit     (u_bit),
      .w_bit     (w_bit),
      .imm       (imm),
      .base_val  (base_val),
      .mode      (dec_mode),
      .first_addr(dec_first),
      .moved_base(dec_moved),
      .wb_req    (dec_wb)
   );

   assign launch = start && (state == ST_IDLE) && (dec_mode != XM_BAD);
   assign accept = (state == ST_BURST) && mem_ready;

   cpxfer_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_agen (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (launch),
      .load_val(dec_first),
      .step    (accept),
      .addr    (xfer_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode_q    <= XM_PRE;
         wb_req_q  <= 1'b0;
         wb_val_q  <= '0;
         wb_idx_q  <= '0;
         opt_q     <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= start && (state == ST_IDLE) && (dec_mode == XM_BAD);
         case (state)
            ST_IDLE: if (launch) begin
               state    <= ST_BURST;
               mode_q   <= dec_mode;
               wb_req_q <= dec_wb;
               wb_val_q <= dec_moved;
               wb_idx_q <= base_idx;
               opt_q    <= imm;
            end
            ST_BURST: if (accept && cp_last) state <= ST_FIN;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign xfer_valid = (state == ST_BURST);
   assign done       = (state == ST_FIN);
   assign wb_en      = (state == ST_FIN) && wb_req_q;
   assign wb_idx     = wb_idx_q;
   assign wb_val     = wb_val_q;
   assign illegal    = illegal_q;
   assign cp_opt     = (state == ST_BURST && mode_q == XM_UNIDX) ? opt_q : '0;

   // R2: an unindexed instruction never writes the base back
   p_unidx_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (mode_q != XM_UNIDX));

   // R4: nothing is presented after the word carrying the end mark
   p_stop_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && mem_ready && cp_last) |=> (!xfer_valid && done));

   // R8: accepted words step by one word; stalled cycles hold the address
   p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && mem_ready && !cp_last) |=> (xfer_addr == $past(xfer_addr) + AW'(WORD_BYTES)));
   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !mem_ready) |=> (xfer_valid && $stable(xfer_addr)));

   // R9: writeback only in the cycle right after the final accepted word
   p_wb_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(xfer_valid && mem_ready && cp_last));

   // R7: a rejected form never starts a burst
   p_illegal_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!busy && !xfer_valid && !wb_en));

   // R3: the option byte stays fixed across an unindexed burst
   p_opt_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !$rose(xfer_valid)) |-> $stable(cp_opt));
endmodule

// File: tb/cpxfer_seq_bench.sv
module cpxfer_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        p_bit = 1'b0, u_bit = 1'b0, w_bit = 1'b0;
   logic [7:0]  imm = '0;
   logic [3:0]  base_idx = '0;
   logic [31:0] base_val = '0;
   logic        mem_ready = 1'b0;
   logic        cp_last = 1'b0;
   logic        busy, xfer_valid, done, wb_en, illegal;
   logic [31:0] xfer_addr, wb_val;
   logic [7:0]  cp_opt;
   logic [3:0]  wb_idx;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   cpxfer_seq u_cpxfer_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .p_bit(p_bit), .u_bit(u_bit),
      .w_bit(w_bit), .imm(imm), .base_idx(base_idx), .base_val(base_val),
      .mem_ready(mem_ready), .cp_last(cp_last), .busy(busy),
      .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .cp_opt(cp_opt),
      .done(done), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
      .illegal(illegal)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !xfer_valid && !done && !wb_en && !illegal, "R10", "idle after reset",
          {busy, xfer_valid, done, wb_en, illegal}, 0);
   endtask

   task automatic run_xfer(input bit p, input bit u, input bit w, input logic [7:0] im,
                           input logic [31:0] base, input logic [3:0] idx,
                           input int n, input bit stall, input bit poke);
      logic [31:0] off, moved, exp_addr;
      bit unidx;
      string rq;
      int k, cyc;
      off      = {22'd0, im, 2'b00};
      moved    = u ? base + off : base - off;
      unidx    = !p && u && !w;
      exp_addr = p ? moved : base;
      rq       = unidx ? "R1" : (p ? "R5" : "R6");
      start = 1'b1; p_bit = p; u_bit = u; w_bit = w; imm = im;
      base_idx = idx; base_val = base;
      @(negedge clk);
      start = 1'b0;
      k = 0; cyc = 0;
      while (k < n && cyc < 100) begin
         chk(busy && xfer_valid && !done && !wb_en, "R9", "burst active, no writeback",
             {busy, xfer_valid, done, wb_en}, 4'b1100);
         chk(xfer_addr == exp_addr, (k == 0) ? rq : "R8", "address", xfer_addr, exp_addr);
         chk(cp_opt == (unidx ? im : 8'h00), "R3", "option byte", cp_opt, unidx ? im : 8'h00);
         if (poke && cyc == 0) begin
            start = 1'b1; p_bit = 1'b1; u_bit = 1'b0; w_bit = 1'b1; imm = 8'hFF;
            base_idx = ~idx; base_val = 32'hDEAD_0000;
         end else start = 1'b0;
         mem_ready = !(stall && (cyc % 2 == 0));
         cp_last   = mem_ready && (k == n - 1);
         @(negedge clk);
         start = 1'b0;
         if (mem_ready) begin
            k++;
            exp_addr = exp_addr + 32'd4;
         end
         cyc++;
      end
      mem_ready = 1'b0; cp_last = 1'b0;
      chk(!xfer_valid && done, "R4", "end after last word", {xfer_valid, done}, 2'b01);
      chk(wb_en == (w && !unidx), unidx ? "R2" : rq, "writeback strobe", wb_en, w && !unidx);
      if (wb_en) begin
         chk(wb_val == moved, rq, "writeback value", wb_val, moved);
         chk(wb_idx == idx, "R9", "writeback index", wb_idx, idx);
      end
      if (poke) chk(wb_idx == idx, "R11", "start while busy ignored", wb_idx, idx);
      @(negedge clk);
      chk(!busy && !done && !wb_en && !xfer_valid, "R4", "single completion",
          {busy, done, wb_en, xfer_valid}, 0);
   endtask

   task automatic t_illegal();
      start = 1'b1; p_bit = 1'b0; u_bit = 1'b0; w_bit = 1'b0; imm = 8'h12;
      base_idx = 4'd3; base_val = 32'h0000_4000;
      @(negedge clk);
      start = 1'b0;
      chk(illegal && !busy && !xfer_valid && !wb_en, "R7", "illegal reported",
          {illegal, busy, xfer_valid, wb_en}, 4'b1000);
      @(negedge clk);
      chk(!illegal && !busy && !xfer_valid && !wb_en, "R7", "illegal one cycle",
          {illegal, busy, xfer_valid, wb_en}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      run_xfer(1'b0, 1'b1, 1'b0, 8'hA5, 32'h0000_1000, 4'd2, 4, 1'b0, 1'b0);
      run_xfer(1'b0, 1'b1, 1'b0, 8'h3C, 32'h0000_2000, 4'd7, 3, 1'b1, 1'b1);
      run_xfer(1'b0, 1'b1, 1'b0, 8'hFF, 32'h0000_3000, 4'd1, 1, 1'b1, 1'b0);
      run_xfer(1'b1, 1'b1, 1'b1, 8'h10, 32'h0000_8000, 4'd5, 2, 1'b0, 1'b0);
      run_xfer(1'b1, 1'b0, 1'b0, 8'h04, 32'h0000_8000, 4'd6, 2, 1'b1, 1'b0);
      run_xfer(1'b1, 1'b0, 1'b1, 8'h08, 32'h0000_0100, 4'd9, 3, 1'b0, 1'b0);
      run_xfer(1'b0, 1'b0, 1'b1, 8'h20, 32'h0000_9000, 4'd11, 2, 1'b1, 1'b0);
      run_xfer(1'b0, 1'b1, 1'b1, 8'h02, 32'hFFFF_FFF8, 4'd14, 3, 1'b0, 1'b0);
      t_illegal();
      run_xfer(1'b0, 1'b1, 1'b0, 8'h00, 32'h0000_0040, 4'd0, 2, 1'b0, 1'b0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule